// File: doc/BRIEF.md
# Multi-Channel Selectable Clock Prescaler

This block turns one selectable source rate into three independently programmable clock-enable streams for peripherals. A free-running binary counter advances once for every tick of the chosen source. The source is either a low-speed oscillator tick or a high-speed oscillator/PLL tick. Every output is a one-cycle enable pulse in the system clock domain, so downstream logic never crosses a clock boundary.

Three channels share the counter. The first timer channel (lower nibble of the timer register) uses an extended tap table that reaches /2048 and /4096. The second timer channel (upper nibble) and the converter channel use the uniform /2 to /256 table. Each channel is a two-state machine. STOP is the idle state. RUN is the active state. The START transition goes from STOP to RUN when the channel's enable bit is 1, and it latches the ratio code. The HALT transition goes from RUN to STOP when the enable bit is 0. The RELOAD transition stays in RUN and relatches the ratio code on each output pulse. A global run bit freezes the counter and silences every channel at once.

Registers are written over a byte-wide bus. They can also be read back through a combinational read port.

Top module: `pclk_prescaler`

## Requirements
- R1: After reset, the control register (address 2) reads 0x02, which means run=1 and source select=0. The timer register (address 0) and the converter register (address 1) read 0x00. No output pulses.
- R2: On the second timer channel and the converter channel, ratio code c gives one pulse every 2^(c+1) source advances. Each pulse falls where the low c+1 counter bits are all ones as the counter advances.
- R3: On the first timer channel, codes 0 to 5 give a period of 2^(c+1) advances, code 6 gives 2048 and code 7 gives 4096, with the same alignment rule as R2.
- R4: A channel with its enable bit at 0 never pulses. After its enable bit is written to 1, it enters RUN on the next clock edge, so its first possible pulse is in the second cycle after the write.
- R5: Control bit 0 selects the source: 1 means ls_tick and 0 means hs_tick. Ticks on the unselected source neither advance the counter nor produce pulses.
- R6: Control bit 1 is the run bit. While it is 0, all outputs stay low and the counter holds its value. When it returns to 1, counting resumes from the held value.
- R7: A ratio code written while a channel is in RUN takes effect only after that channel's next pulse. Up to that pulse, the old tap is used.
- R8: Register layout. Address 0 holds bit 7 (second timer enable), bits 6:4 (its code), bit 3 (first timer enable) and bits 2:0 (its code). Address 1 holds bit 3 (converter enable) and bits 2:0 (its code), and bits 7:4 read 0. Address 2 holds bit 1 (run) and bit 0 (source select), and the other bits read 0. Address 3 reads 0.
- R9: Each pulse lasts one cycle and only occurs in a cycle where the selected source ticks while the run bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hs_tick | input | 1 | High-speed oscillator/PLL tick enable |
| ls_tick | input | 1 | Low-speed oscillator tick enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| tmr_lo_tick | output | 1 | First timer channel pulse (extended table) |
| tmr_hi_tick | output | 1 | Second timer channel pulse |
| adc_tick | output | 1 | Converter channel pulse |

## Verification
The hardest situation to reach is the /2048 and /4096 taps on the first timer channel. Reaching them needs thousands of source advances. The ratio code must also be rewritten mid-period, so that the RELOAD timing of R7 is exercised rather than a fresh START. The stimulus holds hs_tick continuously high through the long taps. It then rewrites codes at short, uneven intervals while channels remain enabled. Irregular pseudo-random source patterns and sparse low-speed ticks are also applied. A behavioural model tracks the counter and each channel's latched code, and it is compared on every cycle.

// File: rtl/psc_pkg.sv
package psc_pkg;

    typedef enum logic {
        CH_STOP = 1'b0,
        CH_RUN  = 1'b1
    } ch_state_e;

    localparam logic [1:0] ADR_TMR = 2'd0;
    localparam logic [1:0] ADR_ADC = 2'd1;
    localparam logic [1:0] ADR_CTL = 2'd2;

    // Counter bit index whose all-ones prefix marks a pulse: index i gives /2^(i+1)
    function automatic logic [3:0] tap_idx(input logic [2:0] code, input logic ext);
        logic [3:0] idx;
        if (ext && code == 3'd6)      idx = 4'd10;
        else if (ext && code == 3'd7) idx = 4'd11;
        else                          idx = {1'b0, code};
        return idx;
    endfunction

endpackage

// File: rtl/psc_divider.sv
module psc_divider #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             src_sel,
    input  logic             hs_tick,
    input  logic             ls_tick,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] hit
);

    logic adv;

    assign adv = run & (src_sel ? ls_tick : hs_tick);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt <= '0;
        else if (adv) cnt <= cnt + 1'b1;
    end

    for (genvar i = 0; i < CNT_W; i++) begin : g_hit
        assign hit[i] = adv & (&cnt[i:0]);
    end

endmodule

// File: rtl/psc_channel.sv
module psc_channel
    import psc_pkg::*;
#(
    parameter bit EXT   = 1'b0,
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [2:0]       code,
    input  logic [CNT_W-1:0] hit,
    output logic             tick
);

    ch_state_e  st_q, st_d;
    logic [2:0] act_q, act_d;
    logic [3:0] idx;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= CH_STOP;
            act_q <= '0;
        end else begin
            st_q  <= st_d;
            act_q <= act_d;
        end
    end

    // Outputs
    always_comb begin
        idx  = tap_idx(act_q, EXT);
        tick = (st_q == CH_RUN) && en && hit[idx];
    end

    // Next state: START, HALT, RELOAD
    always_comb begin
        st_d  = st_q;
        act_d = act_q;
        unique case (st_q)
            CH_STOP: begin
                if (en) begin
                    st_d  = CH_RUN;
                    act_d = code;
                end
            end
            CH_RUN: begin
                if (!en)       st_d  = CH_STOP;
                else if (tick) act_d = code;
            end
        endcase
    end

endmodule

// File: rtl/psc_regs.sv
module psc_regs
    import psc_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [2:0]        ch_en,
    output logic [2:0][2:0]   ch_code,
    output logic              src_sel,
    output logic              run
);

    logic [7:0] tmr_q;
    logic [3:0] adc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q   <= '0;
            adc_q   <= '0;
            src_sel <= 1'b0;
            run     <= 1'b1;
        end else if (wr_en) begin
            if (wr_addr == ADDR_W'(ADR_TMR)) tmr_q <= wr_data[7:0];
            if (wr_addr == ADDR_W'(ADR_ADC)) adc_q <= wr_data[3:0];
            if (wr_addr == ADDR_W'(ADR_CTL)) begin
                src_sel <= wr_data[0];
                run     <= wr_data[1];
            end
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(ADR_TMR)) rd_data[7:0] = tmr_q;
        if (rd_addr == ADDR_W'(ADR_ADC)) rd_data[3:0] = adc_q;
        if (rd_addr == ADDR_W'(ADR_CTL)) rd_data[1:0] = {run, src_sel};
    end

    assign ch_en   = {adc_q[3], tmr_q[7], tmr_q[3]};
    assign ch_code = {adc_q[2:0], tmr_q[6:4], tmr_q[2:0]};

endmodule

// File: rtl/pclk_prescaler.sv
module pclk_prescaler #(
    parameter int ADDR_W = 2,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hs_tick,
    input  logic              ls_tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              tmr_lo_tick,
    output logic              tmr_hi_tick,
    output logic              adc_tick
);

    localparam int         NUM_CH   = 3;
    localparam logic [2:0] EXT_MASK = 3'b001;

    logic [NUM_CH-1:0]      ch_en;
    logic [NUM_CH-1:0][2:0] ch_code;
    logic [NUM_CH-1:0]      tick_vec;
    logic                   src_sel;
    logic                   run_q;
    logic [CNT_W-1:0]       div_cnt;
    logic [CNT_W-1:0]       hit;

    psc_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .ch_en   (ch_en),
        .ch_code (ch_code),
        .src_sel (src_sel),
        .run     (run_q)
    );

    psc_divider #(.CNT_W(CNT_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run_q),
        .src_sel (src_sel),
        .hs_tick (hs_tick),
        .ls_tick (ls_tick),
        .cnt     (div_cnt),
        .hit     (hit)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        psc_channel #(.EXT(EXT_MASK[g]), .CNT_W(CNT_W)) u_ch (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (ch_en[g]),
            .code  (ch_code[g]),
            .hit   (hit),
            .tick  (tick_vec[g])
        );
    end

    assign tmr_lo_tick = tick_vec[0];
    assign tmr_hi_tick = tick_vec[1];
    assign adc_tick    = tick_vec[2];

endmodule

// File: rtl/psc_checker.sv
module psc_checker #(
    parameter int ADDR_W = 2,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run,
    input logic              src_sel,
    input logic              hs_tick,
    input logic              ls_tick,
    input logic [2:0]        ch_en,
    input logic [2:0]        tick_vec,
    input logic [CNT_W-1:0]  div_cnt,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [DATA_W-1:0] rd_data
);

    AST_HALT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> tick_vec == 3'b000); // R6

    AST_HALT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(div_cnt)); // R6

    AST_TICK_ON_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        tick_vec != 3'b000 |-> (src_sel ? ls_tick : hs_tick)); // R9

    AST_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (tick_vec & $past(tick_vec)) == 3'b000); // R9

    AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_vec & ~ch_en) == 3'b000); // R4

    AST_ADC_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
        rd_addr == ADDR_W'(1) |-> rd_data[DATA_W-1:4] == '0); // R8

endmodule

bind pclk_prescaler psc_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run_q),
    .src_sel  (src_sel),
    .hs_tick  (hs_tick),
    .ls_tick  (ls_tick),
    .ch_en    (ch_en),
    .tick_vec (tick_vec),
    .div_cnt  (div_cnt),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data)
);

// File: tb/pclk_prescaler_tb.sv
module pclk_prescaler_tb;

    localparam time CLK_PERIOD = 10ns;
    localparam int  WDOG_LIMIT = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hs_tick = 1'b0;
    logic       ls_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       tmr_lo_tick, tmr_hi_tick, adc_tick;

    pclk_prescaler u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .hs_tick     (hs_tick),
        .ls_tick     (ls_tick),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .rd_addr     (rd_addr),
        .rd_data     (rd_data),
        .tmr_lo_tick (tmr_lo_tick),
        .tmr_hi_tick (tmr_hi_tick),
        .adc_tick    (adc_tick)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int    n_cmp = 0;
    int    n_bad = 0;
    int    cyc   = 0;
    string req   = "R1";
    int    hs_mode = 0;   // 0: always on, 1: pseudo-random
    int    ls_gap  = 7;
    logic [15:0] lfsr = 16'hACE1;
    bit    done = 0;

    // ---------------- behavioural reference model ----------------
    logic [7:0] m_tmr;
    logic [3:0] m_adc;
    bit         m_sel, m_run;
    int         m_cnt;
    bit         m_st  [3];
    int         m_act [3];

    function automatic bit m_en(int c);
        if (c == 0) return m_tmr[3];
        if (c == 1) return m_tmr[7];
        return m_adc[3];
    endfunction

    function automatic int m_code(int c);
        if (c == 0) return int'(m_tmr[2:0]);
        if (c == 1) return int'(m_tmr[6:4]);
        return int'(m_adc[2:0]);
    endfunction

    function automatic int period(int c, int code);
        if (c == 0 && code == 6) return 2048;
        if (c == 0 && code == 7) return 4096;
        return 2 << code;
    endfunction

    function automatic bit m_adv();
        return m_run && (m_sel ? ls_tick : hs_tick);
    endfunction

    function automatic bit m_tick(int c);
        int p;
        p = period(c, m_act[c]);
        return m_en(c) && m_st[c] && m_adv() && ((m_cnt % p) == p - 1);
    endfunction

    function automatic logic [7:0] m_rd(logic [1:0] a);
        case (a)
            2'd0:    return m_tmr;
            2'd1:    return {4'h0, m_adc};
            2'd2:    return {6'h0, m_run, m_sel};
            default: return 8'h00;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_tmr = '0; m_adc = '0; m_sel = 0; m_run = 1; m_cnt = 0;
            for (int c = 0; c < 3; c++) begin m_st[c] = 0; m_act[c] = 0; end
        end else begin
            bit tk [3];
            bit adv;
            adv = m_adv();
            for (int c = 0; c < 3; c++) tk[c] = m_tick(c);
            for (int c = 0; c < 3; c++) begin
                if (!m_en(c))        m_st[c] = 0;
                else if (!m_st[c]) begin m_st[c] = 1; m_act[c] = m_code(c); end
                else if (tk[c])      m_act[c] = m_code(c);
            end
            if (adv) m_cnt = (m_cnt + 1) % 4096;
            if (wr_en) begin
                case (wr_addr)
                    2'd0: m_tmr = wr_data;
                    2'd1: m_adc = wr_data[3:0];
                    2'd2: begin m_sel = wr_data[0]; m_run = wr_data[1]; end
                    default: ;
                endcase
            end
        end
    end

    // ---------------- stimulus drivers ----------------
    always @(negedge clk) begin
        lfsr    <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        hs_tick <= (hs_mode == 0) ? 1'b1 : lfsr[3];
        ls_tick <= (cyc % ls_gap) == 0;
        rd_addr <= rd_addr + 2'd1;
    end

    always @(posedge clk) cyc <= cyc + 1;

    // ---------------- comparison ----------------
    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s cycle %0d: actual %0h expected %0h", tag, cyc, act, exp);
        end
    endtask

    always @(negedge clk) begin
        #2;
        if (rst_n && !done) begin
            // R3 extended channel, R2 uniform channels
            chk({req, "/R3 tmr_lo"}, {7'h0, tmr_lo_tick}, {7'h0, m_tick(0)});
            chk({req, "/R2 tmr_hi"}, {7'h0, tmr_hi_tick}, {7'h0, m_tick(1)});
            chk({req, "/R2 adc"},    {7'h0, adc_tick},    {7'h0, m_tick(2)});
            chk({req, "/R8 rd_data"}, rd_data, m_rd(rd_addr));
        end
    end

    // ---------------- watchdog ----------------
    always @(posedge clk) begin
        if (cyc > WDOG_LIMIT && !done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog: actual cycle %0d expected below %0d", cyc, WDOG_LIMIT);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic wr(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        idle(4);
        rst_n = 1'b1;
        // R1: reset values and silent outputs
        req = "R1";
        idle(8);

        // R2 / R3: sweep every ratio code on all channels
        for (int c = 0; c < 8; c++) begin
            req = "R2R3";
            wr(2'd0, {1'b1, 3'(c), 1'b1, 3'(c)});
            wr(2'd1, {4'h0, 1'b1, 3'(7 - c)});
            idle(2 * period(0, c) + 600);
        end

        // R7: rewrite codes mid-period while channels stay enabled
        req = "R7";
        wr(2'd0, 8'h92);
        for (int k = 0; k < 12; k++) begin
            wr(2'd0, {1'b1, 3'(k % 5), 1'b1, 3'((k * 3) % 6)});
            wr(2'd1, {4'h0, 1'b1, 3'((k + 2) % 8)});
            idle(3 + (k * 7) % 23);
        end
        idle(300);

        // R4: disable and re-enable channels
        req = "R4";
        wr(2'd0, 8'h08);
        idle(40);
        wr(2'd1, 8'h00);
        idle(40);
        wr(2'd0, 8'h80);
        idle(40);
        wr(2'd0, 8'hA9);
        wr(2'd1, 8'h0A);
        idle(200);

        // R9: irregular high-speed source
        req = "R9";
        hs_mode = 1;
        idle(1500);

        // R5: low-speed source selected, high-speed keeps toggling
        req = "R5";
        wr(2'd2, 8'h03);
        ls_gap = 5;
        idle(1200);
        ls_gap = 3;
        idle(600);
        wr(2'd2, 8'h02);
        idle(300);

        // R6: halt and resume from held count
        req = "R6";
        wr(2'd0, 8'h88);
        wr(2'd1, 8'h08);
        idle(13);
        wr(2'd2, 8'h00);
        idle(120);
        wr(2'd2, 8'h02);
        idle(200);
        wr(2'd2, 8'h01);
        idle(60);
        wr(2'd2, 8'h03);
        idle(300);

        // R8: reserved bits and unused address
        req = "R8";
        wr(2'd1, 8'hFB);
        wr(2'd2, 8'hFE);
        wr(2'd3, 8'hFF);
        idle(80);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule